// File: doc/BRIEF.md
# Programmable Safe Petri-Net Controller

This block runs a safe Petri net whose arcs live in a writable configuration array, not in fixed wiring. Each transition owns one row of that array. Each row holds a two-bit code for every column. The columns are the start place, the internal places, the two halves of each handshake place, and the true/false halves of each decision line. Every place carries at most one token. On each clock edge every enabled transition fires in a single step: its input places are emptied and its output places are filled.

A place can stand for an external module. Filling such a place toggles a ready line to that module. The place only counts as full once the module toggles its acknowledge line to match, which is two-phase signalling. Decision inputs steer tokens: a transition that uses a decision column fires only while that line has the matching value.

Transitions are grouped in adjacent pairs, (0,1), (2,3) and so on. When both transitions of a pair want the same token, a per-pair arbiter lets exactly one of them fire. The arbiter alternates which one it favours from one such contest to the next. The net is held while `go_i` is low. In that state the marking is kept at its initial value, and this is the only time the configuration array can be written. A firing that would put a second token into an occupied place sets a sticky error flag.

Top module: `petri_net_ctrl`

## Requirements
- R1: While `go_i` is low (and after reset) no transition fires, the error flag is cleared, and the marking is the start place full, the internal places at `INIT_INT` and every handshake place empty. The marking is reported on `mark_o` with bit 0 for the start place, bits 1..4 for internal places 0..3 and bits 5..8 for handshake places 0..3.
- R2: A row holds 17 two-bit cells, with cell c at bits [2c+1:2c]. Cell 0 is the start place and cells 1..4 are internal places 0..3. Handshake place k uses cell 5+2k as its output half and cell 6+2k as its input half. Decision line d uses cell 13+2d as its true half and cell 14+2d as its false half. Code 01 marks an input arc, code 10 marks an output arc, and codes 00 and 11 mark no arc.
- R3: A transition is enabled only when every place it reads is full and its row reads at least one place. Enabled transitions are shown combinationally on `fire_o` and fire at the next clock edge.
- R4: Firing empties all input places and fills all output places in the same clock edge.
- R5: Filling a handshake place toggles its ready line at that edge. The place becomes full at the first edge at which the acknowledge line equals the ready line.
- R6: A true-half input arc enables its transition only while that decision input is 1, and a false-half input arc only while it is 0.
- R7: If both transitions of a pair are enabled and read a common place, exactly one fires. The lower one wins the first such contest after hold, and the winner alternates on each later contest.
- R8: A firing that would fill a place that is already occupied and is not being emptied at the same edge, or two firings that fill the same place, sets `err_o`. The flag stays set until the net is held.
- R9: Configuration writes are accepted only while `go_i` is low. Writes while the net runs have no effect.
- R10: A row with output arcs but no place input arc never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go_i | input | 1 | Run when high; hold and allow configuration when low |
| dec_i | input | N_DEC | Decision lines |
| ack_i | input | N_IO | Acknowledge lines from external modules |
| rdy_o | output | N_IO | Ready lines to external modules (toggle per request) |
| cfg_we_i | input | 1 | Configuration row write strobe |
| cfg_row_i | input | clog2(N_TRANS) | Transition row being written |
| cfg_data_i | input | 2*(1+N_INT+2*N_IO+2*N_DEC) | Row contents, two bits per cell |
| mark_o | output | 1+N_INT+N_IO | Current full/empty state of every place |
| fire_o | output | N_TRANS | Transitions firing at the next edge |
| err_o | output | 1 | Sticky unsafe-net error |

## Verification
The bench drives a fork/join net through a handshake place, a decision branch, and a contended pair that is fed twice more so that the alternation of the winner can be seen. A design that let both sides of a tie fire would fill two handshake places at once. A design that never alternated would serve the lower transition every time. The bench runs the opposite decision value and expects the token on the other branch; swapping the true and false halves would send it the wrong way. It builds a net that refills an occupied place and checks that the error is raised and then held. It also checks that a row with no input arc stays idle, and that a write issued while the net runs leaves the net unchanged.

// File: rtl/petri_pkg.sv
`timescale 1ns/1ps
package petri_pkg;
   typedef enum logic [1:0] {
      ARC_NONE = 2'b00,
      ARC_IN   = 2'b01,
      ARC_OUT  = 2'b10,
      ARC_RSV  = 2'b11
   } arc_e;
endpackage

// File: rtl/petri_row_dec.sv
`timescale 1ns/1ps
module petri_row_dec
   import petri_pkg::*;
#(
   parameter int N_INT = 4,
   parameter int N_IO  = 4,
   parameter int N_DEC = 2
)(
   input  logic [2*(1+N_INT+2*N_IO+2*N_DEC)-1:0] row_i,
   input  logic [N_INT+N_IO:0]                   full_i,
   input  logic [N_DEC-1:0]                      dec_i,
   input  logic                                  go_i,
   output logic [N_INT+N_IO:0]                   in_mask_o,
   output logic [N_INT+N_IO:0]                   out_mask_o,
   output logic                                  en_o
);
   localparam int IO_C0 = 1 + N_INT;
   localparam int DC_C0 = IO_C0 + 2*N_IO;

   logic dec_ok;

   always_comb begin
      in_mask_o  = '0;
      out_mask_o = '0;
      // start place: may only be read
      in_mask_o[0] = (row_i[1:0] == ARC_IN);
      for (int i = 0; i < N_INT; i++) begin
         in_mask_o[1+i]  = (row_i[2*(1+i) +: 2] == ARC_IN);
         out_mask_o[1+i] = (row_i[2*(1+i) +: 2] == ARC_OUT);
      end
      for (int i = 0; i < N_IO; i++) begin
         out_mask_o[IO_C0+i] = (row_i[2*(IO_C0+2*i)   +: 2] == ARC_OUT);
         in_mask_o[IO_C0+i]  = (row_i[2*(IO_C0+2*i+1) +: 2] == ARC_IN);
      end
      dec_ok = 1'b1;
      for (int d = 0; d < N_DEC; d++) begin
         if ((row_i[2*(DC_C0+2*d)   +: 2] == ARC_IN) && !dec_i[d]) dec_ok = 1'b0;
         if ((row_i[2*(DC_C0+2*d+1) +: 2] == ARC_IN) &&  dec_i[d]) dec_ok = 1'b0;
      end
      en_o = go_i && (|in_mask_o) && dec_ok && ((in_mask_o & full_i) == in_mask_o);
   end
endmodule

// File: rtl/petri_pair_arb.sv
`timescale 1ns/1ps
module petri_pair_arb #(
   parameter int NPL = 9
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold_i,
   input  logic [1:0]     en_i,
   input  logic [NPL-1:0] in_a_i,
   input  logic [NPL-1:0] in_b_i,
   output logic [1:0]     gnt_o
);
   logic prio_q;   // 0: lower transition favoured
   logic tie;

   assign tie   = en_i[0] && en_i[1] && (|(in_a_i & in_b_i));
   assign gnt_o = tie ? (prio_q ? 2'b10 : 2'b01) : en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prio_q <= 1'b0;
      else if (hold_i) prio_q <= 1'b0;
      else if (tie)    prio_q <= ~prio_q;
   end

   a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      tie |-> ($countones(gnt_o) == 1));
   a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
      (tie && gnt_o[0]) |=> (!tie || gnt_o[1]));
endmodule

// File: rtl/petri_io_place.sv
`timescale 1ns/1ps
module petri_io_place (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic ack_i,
   output logic rdy_o,
   output logic busy_o,
   output logic full_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_o  <= 1'b0;
         busy_o <= 1'b0;
         full_o <= 1'b0;
      end else if (hold_i) begin
         busy_o <= 1'b0;
         full_o <= 1'b0;
      end else begin
         if (clr_i) full_o <= 1'b0;
         if (busy_o && (ack_i == rdy_o)) begin
            busy_o <= 1'b0;
            full_o <= 1'b1;
         end
         if (set_i) begin
            rdy_o  <= ~rdy_o;
            busy_o <= 1'b1;
         end
      end
   end

   a_r5_request_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !hold_i) |=> (rdy_o != $past(rdy_o)));
   a_r5_full_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (ack_i == rdy_o) && !hold_i && !set_i) |=> full_o);
endmodule

// File: rtl/petri_net_ctrl.sv
`timescale 1ns/1ps
module petri_net_ctrl #(
   parameter int               N_INT    = 4,
   parameter int               N_IO     = 4,
   parameter int               N_DEC    = 2,
   parameter int               N_TRANS  = 8,
   parameter logic [N_INT-1:0] INIT_INT = '0
)(
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  go_i,
   input  logic [N_DEC-1:0]                      dec_i,
   input  logic [N_IO-1:0]                       ack_i,
   output logic [N_IO-1:0]                       rdy_o,
   input  logic                                  cfg_we_i,
   input  logic [$clog2(N_TRANS)-1:0]            cfg_row_i,
   input  logic [2*(1+N_INT+2*N_IO+2*N_DEC)-1:0] cfg_data_i,
   output logic [N_INT+N_IO:0]                   mark_o,
   output logic [N_TRANS-1:0]                    fire_o,
   output logic                                  err_o
);
   localparam int NPL   = 1 + N_INT + N_IO;
   localparam int ROW_W = 2*(1 + N_INT + 2*N_IO + 2*N_DEC);
   localparam int IO_P0 = 1 + N_INT;

   if (N_TRANS < 2 || (N_TRANS % 2) != 0) begin : g_bad_pairs
      $error("N_TRANS must be even and at least 2");
   end
   if (N_INT < 1 || N_IO < 1 || N_DEC < 1) begin : g_bad_counts
      $error("place and decision counts must be at least 1");
   end

   logic [ROW_W-1:0]   cfg_q [N_TRANS];
   logic [N_INT:0]     tok_q;
   logic [N_IO-1:0]    io_full, io_busy;
   logic [NPL-1:0]     full_v, occ_v, clr_v, set_v;
   logic [NPL-1:0]     in_m  [N_TRANS];
   logic [NPL-1:0]     out_m [N_TRANS];
   logic [N_TRANS-1:0] en_v, gnt_v;
   logic               ovf, err_q;

   assign full_v = {io_full, tok_q};
   assign occ_v  = {io_full | io_busy, tok_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < N_TRANS; t++) cfg_q[t] <= '0;
      end else if (cfg_we_i && !go_i && (int'(cfg_row_i) < N_TRANS)) begin
         cfg_q[cfg_row_i] <= cfg_data_i;
      end
   end

   for (genvar t = 0; t < N_TRANS; t++) begin : g_row
      petri_row_dec #(.N_INT(N_INT), .N_IO(N_IO), .N_DEC(N_DEC)) u_dec (
         .row_i      (cfg_q[t]),
         .full_i     (full_v),
         .dec_i      (dec_i),
         .go_i       (go_i),
         .in_mask_o  (in_m[t]),
         .out_mask_o (out_m[t]),
         .en_o       (en_v[t])
      );
      a_r9_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         go_i |=> $stable(cfg_q[t]));
   end

   for (genvar k = 0; k < N_TRANS/2; k++) begin : g_pair
      petri_pair_arb #(.NPL(NPL)) u_arb (
         .clk    (clk),
         .rst_n  (rst_n),
         .hold_i (!go_i),
         .en_i   (en_v[2*k +: 2]),
         .in_a_i (in_m[2*k]),
         .in_b_i (in_m[2*k+1]),
         .gnt_o  (gnt_v[2*k +: 2])
      );
   end

   always_comb begin
      clr_v = '0;
      set_v = '0;
      ovf   = 1'b0;
      for (int t = 0; t < N_TRANS; t++) begin
         if (gnt_v[t]) begin
            ovf   = ovf | (|(set_v & out_m[t]));
            clr_v = clr_v | in_m[t];
            set_v = set_v | out_m[t];
         end
      end
      ovf = ovf | (|(set_v & occ_v & ~clr_v));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok_q <= {INIT_INT, 1'b1};
         err_q <= 1'b0;
      end else if (!go_i) begin
         tok_q <= {INIT_INT, 1'b1};
         err_q <= 1'b0;
      end else begin
         tok_q <= (tok_q & ~clr_v[N_INT:0]) | set_v[N_INT:0];
         if (ovf) err_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < N_IO; i++) begin : g_io
      petri_io_place u_io (
         .clk    (clk),
         .rst_n  (rst_n),
         .hold_i (!go_i),
         .set_i  (set_v[IO_P0+i]),
         .clr_i  (clr_v[IO_P0+i]),
         .ack_i  (ack_i[i]),
         .rdy_o  (rdy_o[i]),
         .busy_o (io_busy[i]),
         .full_o (io_full[i])
      );
   end

   assign mark_o = full_v;
   assign fire_o = gnt_v;
   assign err_o  = err_q;

   a_r8_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && go_i) |=> err_o);
   a_r1_hold_marking: assert property (@(posedge clk) disable iff (!rst_n)
      !go_i |=> (mark_o == {{N_IO{1'b0}}, INIT_INT, 1'b1}) && !err_o);
   a_r1_hold_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
      !go_i |-> (fire_o == '0));
endmodule

// File: tb/petri_net_ctrl_tb.sv
`timescale 1ns/1ps
module petri_net_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [1:0]  dec = 2'b01;
   logic [3:0]  ack = 4'h0;
   logic [3:0]  rdy;
   logic        we = 1'b0;
   logic [2:0]  row = 3'd0;
   logic [33:0] data = '0;
   logic [8:0]  mark;
   logic [7:0]  fire;
   logic        err;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   petri_net_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .go_i(go), .dec_i(dec), .ack_i(ack), .rdy_o(rdy),
      .cfg_we_i(we), .cfg_row_i(row), .cfg_data_i(data),
      .mark_o(mark), .fire_o(fire), .err_o(err)
   );

   // R2 cell layout: code 01 = input arc, 10 = output arc, cell c at bits 2c+1:2c
   function automatic logic [33:0] a_in(input int c);
      return 34'(2'b01) << (2*c);
   endfunction
   function automatic logic [33:0] a_out(input int c);
      return 34'(2'b10) << (2*c);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int r, input logic [33:0] d);
      row = 3'(r); data = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   // {ack toggle, mark, fire, rdy} per cycle of the main run
   localparam logic [24:0] TBL [11] = '{
      {4'h0, 9'h001, 8'h01, 4'h0},
      {4'h1, 9'h002, 8'h00, 4'h1},
      {4'h0, 9'h022, 8'h02, 4'h1},
      {4'h0, 9'h004, 8'h04, 4'h1},
      {4'h0, 9'h008, 8'h10, 4'h1},
      {4'h2, 9'h000, 8'h00, 4'h3},
      {4'h0, 9'h040, 8'h40, 4'h3},
      {4'h0, 9'h008, 8'h20, 4'h3},
      {4'h4, 9'h000, 8'h00, 4'h7},
      {4'h0, 9'h080, 8'h80, 4'h7},
      {4'h0, 9'h008, 8'h10, 4'h7}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset mark", 32'(mark), 32'h001);
      chk("R1 reset rdy", 32'(rdy), 32'h0);
      chk("R1 reset err", 32'(err), 32'h0);
      chk("R1 reset fire", 32'(fire), 32'h0);
      @(negedge clk);
      // program the net while held (R9 accepted path)
      wr(0, a_in(0)  | a_out(1) | a_out(5));
      wr(1, a_in(1)  | a_in(6)  | a_out(2));
      wr(2, a_in(2)  | a_in(13) | a_out(3));
      wr(3, a_in(2)  | a_in(14) | a_out(4));
      wr(4, a_in(3)  | a_out(7));
      wr(5, a_in(3)  | a_out(9));
      wr(6, a_in(8)  | a_out(3));
      wr(7, a_in(10) | a_out(3));
      repeat (3) @(negedge clk);
      chk("R1 hold mark", 32'(mark), 32'h001);
      chk("R1 hold fire", 32'(fire), 32'h0);

      // main run: fork, handshake, join, true branch, contended pair x3
      go = 1'b1;
      for (int i = 0; i < 11; i++) begin
         ack = ack ^ TBL[i][24:21];
         #1;
         chk($sformatf("R4 mark step %0d", i), 32'(mark), 32'(TBL[i][20:12]));
         chk($sformatf("R7 R3 fire step %0d", i), 32'(fire), 32'(TBL[i][11:4]));
         chk($sformatf("R5 rdy step %0d", i), 32'(rdy), 32'(TBL[i][3:0]));
         @(negedge clk);
      end
      chk("R5 rdy after third contest", 32'(rdy), 32'h5);
      chk("R8 no false error", 32'(err), 32'h0);

      // hold, then run the false branch of decision 0
      go = 1'b0;
      @(negedge clk);
      ack[1] = 1'b0;
      chk("R1 rehold mark", 32'(mark), 32'h001);
      dec = 2'b00;
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      ack[0] = ~ack[0];
      repeat (6) @(negedge clk);
      chk("R6 false branch mark", 32'(mark), 32'h010);
      // write while running must be ignored
      wr(7, a_in(4) | a_out(1));
      repeat (3) @(negedge clk);
      chk("R9 running write ignored", 32'(mark), 32'h010);

      // overflow net plus an input-less row
      go = 1'b0;
      dec = 2'b01;
      @(negedge clk);
      wr(0, a_in(0) | a_out(1) | a_out(2) | a_out(5));
      wr(2, a_in(1) | a_out(2));
      wr(7, a_out(1));
      @(negedge clk);
      chk("R8 err clear in hold", 32'(err), 32'h0);
      go = 1'b1;
      #1;
      chk("R10 no-input row idle", 32'(fire), 32'h01);
      @(negedge clk);
      chk("R4 fork mark", 32'(mark), 32'h006);
      chk("R3 refill fire", 32'(fire), 32'h04);
      chk("R8 err before overflow", 32'(err), 32'h0);
      @(negedge clk);
      chk("R8 overflow flagged", 32'(err), 32'h1);
      chk("R4 overflow mark", 32'(mark), 32'h004);
      repeat (3) @(negedge clk);
      chk("R8 err sticky", 32'(err), 32'h1);
      go = 1'b0;
      @(negedge clk);
      chk("R1 err cleared by hold", 32'(err), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule